// File: doc/BRIEF.md
# Cache-Block Operation Decode and Permission Gate

This block sits beside the instruction decoder of a RISC-V hart. Each cycle in which an instruction-valid strobe is high, it examines the 32-bit instruction word and reports, in the same cycle, whether the word is one of the cache-block maintenance operations (clean, flush, invalidate, zero) or one of the prefetch hints that live inside the ORI encoding space. For a maintenance operation it also decides whether the operation may run at the current privilege level. It reports no exception, an illegal-instruction exception or a virtual-instruction exception.

The permission decision reads three environment-configuration registers: one for machine level, one for hypervisor level and one for supervisor level. The block holds these registers itself and exposes them through a simple CSR read and write port. Writes from a privilege below the owning level are dropped. Two elaboration parameters remove the management operations (clean, flush, invalidate) or the zero operation. When removed, they decode as illegal instructions.

Top module: `cbo_gate`

## Requirements
- R1: A word with opcode bits [6:0] = 0001111, bits [14:12] = 010, bits [11:7] = 0 and bits [31:25] = 0 decodes by bits [24:20]: 00001 is clean (opOneHot bit 0), 00010 is flush (bit 1), 00000 is invalidate (bit 2), 00100 is zero (bit 3). Any other value of those fields gives opOneHot = 0. At most one bit of opOneHot is ever set.
- R2: A word with opcode 0010011, bits [14:12] = 110 and bits [11:7] = 0 is a prefetch hint (opOneHot bit 4) when bits [24:20] are 00000, 00001 or 00011, whatever the 7-bit immediate in bits [31:25] holds. Every other word in that space, including a nonzero rd, gives opOneHot = 0. rs1Idx shows bits [19:15] whenever opOneHot is nonzero, and 0 otherwise.
- R3: A prefetch hint always reports exception code 0 (none), at every privilege level and virtualisation state and for any register contents.
- R4: The machine, hypervisor and supervisor configuration registers sit at CSR addresses 0x30A, 0x60A and 0x10A. All three reset to zero and read back on csrRdData. Any other CSR address reads 0 and ignores writes.
- R5: A write takes effect only when privLvl is at least the owner level. Privilege is encoded user = 0, supervisor = 1, machine = 3. The machine register needs privilege 3, the hypervisor register needs privilege 2 or more (so only machine), and the supervisor register needs privilege 1 or more.
- R6: Clean and flush are enabled at a level by bit 6 of that level's register. Invalidate is enabled when bits [5:4] are nonzero. Zero is enabled by bit 7.
- R7: With virtOn high, a maintenance operation reports exception code 2 (virtual instruction) when the privilege is below 2 and the hypervisor enable is clear, or when the privilege is user and the supervisor enable is clear. This check takes precedence over R8.
- R8: When R7 does not fire, a maintenance operation reports exception code 1 (illegal instruction) when the privilege is below machine and the machine enable is clear, or when the privilege is user and the supervisor enable is clear.
- R9: At machine privilege with virtOn low, a decoded maintenance operation always reports exception code 0.
- R10: With parameter EN_BLOCK_MGMT = 0, clean, flush and invalidate words report opOneHot = 0 and exception code 1 at any privilege. With EN_BLOCK_ZERO = 0 the zero word does the same. Prefetch hints are not affected.
- R11: While instValid is low, opOneHot and excCode are 0. Exception code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| privLvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virtOn | input | 1 | Virtualisation active |
| csrWrEn | input | 1 | CSR write strobe |
| csrAddr | input | 12 | CSR address for read and write |
| csrWrData | input | XLEN | CSR write data |
| csrRdData | output | XLEN | CSR read data for csrAddr |
| opOneHot | output | 5 | Decoded operation: clean, flush, inval, zero, prefetch |
| rs1Idx | output | 5 | Base-address register index of the decoded operation |
| excCode | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |

## Verification
The bench targets the places where the exception precedence is easy to get wrong. The first case has both the hypervisor and machine enables clear under virtualisation; a design that checks illegal first would report code 1 instead of 2. The second case has supervisor-mode code with only the supervisor enable clear, where a design that applied the user-only supervisor term to every level would trap wrongly. It probes the invalidate field with only bit 4 and then only bit 5 set, because a design that tests a single bit misses one of them. It also probes ORI words that are one field away from a prefetch hint, which a loose decoder would accept. Writes from too low a privilege are followed by a read-back, so a missing owner check shows up as changed register contents.

// File: rtl/cbo_gate_pkg.sv
package cbo_gate_pkg;

  // Privilege encodings
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_HYPER = 2'd2;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  // Configuration levels held by the bank
  localparam int LVL_M   = 0;
  localparam int LVL_H   = 1;
  localparam int LVL_S   = 2;
  localparam int NUM_LVL = 3;

  // Operation bit positions in the one-hot output
  localparam int OP_CLEAN = 0;
  localparam int OP_FLUSH = 1;
  localparam int OP_INVAL = 2;
  localparam int OP_ZERO  = 3;
  localparam int OP_PREF  = 4;
  localparam int NUM_OPS  = 5;

  // Enable field positions inside a configuration register
  localparam int CFG_GATE_LO = 4;
  localparam int CFG_GATE_W  = 4;
  localparam int GATE_INV_LO = 0;  // register bits 5:4
  localparam int GATE_CF     = 2;  // register bit 6
  localparam int GATE_ZE     = 3;  // register bit 7

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_VIRTUAL = 2'd2
  } excCode_e;

  // Strobes from control to the register bank
  typedef struct packed {
    logic [NUM_LVL-1:0] wrStb;
    logic [NUM_LVL-1:0] rdSel;
  } csrStb_t;

  function automatic logic [11:0] cfgAddr(input int lvl);
    case (lvl)
      LVL_M:   return 12'h30A;
      LVL_H:   return 12'h60A;
      default: return 12'h10A;
    endcase
  endfunction

  function automatic logic [1:0] cfgOwner(input int lvl);
    case (lvl)
      LVL_M:   return PRIV_MACH;
      LVL_H:   return PRIV_HYPER;
      default: return PRIV_SUPER;
    endcase
  endfunction

endpackage

// File: rtl/cbo_cfg_bank.sv
module cbo_cfg_bank
  import cbo_gate_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  csrStb_t                         stb,
  input  logic [XLEN-1:0]                 wrData,
  output logic [NUM_LVL-1:0][XLEN-1:0]    cfgVal,
  output logic [XLEN-1:0]                 rdData
);

  for (genvar lvl = 0; lvl < NUM_LVL; lvl++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgVal[lvl] <= '0;
      end else if (stb.wrStb[lvl]) begin
        cfgVal[lvl] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int lvl = 0; lvl < NUM_LVL; lvl++) begin
      if (stb.rdSel[lvl]) rdData = rdData | cfgVal[lvl];
    end
  end

endmodule

// File: rtl/cbo_gate_ctrl.sv
module cbo_gate_ctrl
  import cbo_gate_pkg::*;
#(
  parameter bit EN_BLOCK_MGMT = 1'b1,
  parameter bit EN_BLOCK_ZERO = 1'b1
) (
  input  logic                                  instValid,
  input  logic [31:0]                           instWord,
  input  logic [1:0]                            privLvl,
  input  logic                                  virtOn,
  input  logic                                  csrWrEn,
  input  logic [11:0]                           csrAddr,
  input  logic [NUM_LVL-1:0][CFG_GATE_W-1:0]    cfgGate,
  output csrStb_t                               stb,
  output logic [NUM_OPS-1:0]                    opOneHot,
  output logic [4:0]                            rs1Idx,
  output logic [1:0]                            excCode
);

  // ---------------- CSR strobes ----------------
  logic [NUM_LVL-1:0] addrHit;
  logic [NUM_LVL-1:0] wrOk;

  for (genvar lvl = 0; lvl < NUM_LVL; lvl++) begin : g_csr
    assign addrHit[lvl] = (csrAddr == cfgAddr(lvl));
    assign wrOk[lvl]    = csrWrEn && addrHit[lvl] && (privLvl >= cfgOwner(lvl));
  end

  assign stb = '{wrStb: wrOk, rdSel: addrHit};

  // ---------------- instruction fields ----------------
  logic [6:0] opcField;
  logic [2:0] fn3Field;
  logic [4:0] rdField;
  logic [4:0] rs1Field;
  logic [4:0] selField;
  logic [6:0] hiField;

  assign opcField = instWord[6:0];
  assign rdField  = instWord[11:7];
  assign fn3Field = instWord[14:12];
  assign rs1Field = instWord[19:15];
  assign selField = instWord[24:20];
  assign hiField  = instWord[31:25];

  logic cboShape;
  logic prefShape;

  assign cboShape  = (opcField == 7'b0001111) && (fn3Field == 3'b010) &&
                     (rdField == 5'd0) && (hiField == 7'd0);
  assign prefShape = (opcField == 7'b0010011) && (fn3Field == 3'b110) &&
                     (rdField == 5'd0);

  logic [NUM_OPS-1:0] rawOp;

  always_comb begin
    rawOp = '0;
    if (cboShape) begin
      case (selField)
        5'b00001: rawOp[OP_CLEAN] = 1'b1;
        5'b00010: rawOp[OP_FLUSH] = 1'b1;
        5'b00000: rawOp[OP_INVAL] = 1'b1;
        5'b00100: rawOp[OP_ZERO]  = 1'b1;
        default:  rawOp = '0;
      endcase
    end else if (prefShape) begin
      case (selField)
        5'b00000, 5'b00001, 5'b00011: rawOp[OP_PREF] = 1'b1;
        default:                      rawOp = '0;
      endcase
    end
  end

  // ---------------- extension gating ----------------
  logic [NUM_OPS-1:0] extGate;

  if (EN_BLOCK_MGMT) begin : g_mgmt_on
    assign extGate[OP_INVAL:OP_CLEAN] = 3'b111;
  end else begin : g_mgmt_off
    assign extGate[OP_INVAL:OP_CLEAN] = 3'b000;
  end

  if (EN_BLOCK_ZERO) begin : g_zero_on
    assign extGate[OP_ZERO] = 1'b1;
  end else begin : g_zero_off
    assign extGate[OP_ZERO] = 1'b0;
  end

  assign extGate[OP_PREF] = 1'b1;

  logic [NUM_OPS-1:0] gatedOp;
  logic               extReject;

  assign gatedOp   = rawOp & extGate;
  assign extReject = |(rawOp & ~extGate);

  // ---------------- per-level enable lookup ----------------
  logic [NUM_LVL-1:0] fieldOn;

  for (genvar lvl = 0; lvl < NUM_LVL; lvl++) begin : g_field
    assign fieldOn[lvl] =
        ((gatedOp[OP_CLEAN] | gatedOp[OP_FLUSH]) & cfgGate[lvl][GATE_CF]) |
        (gatedOp[OP_INVAL] & (|cfgGate[lvl][GATE_INV_LO +: 2])) |
        (gatedOp[OP_ZERO]  & cfgGate[lvl][GATE_ZE]);
  end

  // ---------------- permission decision ----------------
  logic isMaint;
  logic belowHyper;
  logic belowMach;
  logic isUser;
  logic virtTrap;
  logic illTrap;

  assign isMaint    = |gatedOp[OP_ZERO:OP_CLEAN];
  assign belowHyper = (privLvl < PRIV_HYPER);
  assign belowMach  = (privLvl < PRIV_MACH);
  assign isUser     = (privLvl == PRIV_USER);

  assign virtTrap = virtOn &&
                    ((belowHyper && !fieldOn[LVL_H]) || (isUser && !fieldOn[LVL_S]));
  assign illTrap  = (belowMach && !fieldOn[LVL_M]) || (isUser && !fieldOn[LVL_S]);

  excCode_e excNext;

  always_comb begin
    excNext = EXC_NONE;
    if (instValid) begin
      if (extReject)      excNext = EXC_ILLEGAL;
      else if (isMaint) begin
        if (virtTrap)     excNext = EXC_VIRTUAL;
        else if (illTrap) excNext = EXC_ILLEGAL;
      end
    end
  end

  assign excCode  = excNext;
  assign opOneHot = instValid ? gatedOp : '0;
  assign rs1Idx   = (|opOneHot) ? rs1Field : 5'd0;

endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
  import cbo_gate_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter bit EN_BLOCK_MGMT = 1'b1,
  parameter bit EN_BLOCK_ZERO = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  input  logic [1:0]      privLvl,
  input  logic            virtOn,
  input  logic            csrWrEn,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrWrData,
  output logic [XLEN-1:0] csrRdData,
  output logic [4:0]      opOneHot,
  output logic [4:0]      rs1Idx,
  output logic [1:0]      excCode
);

  csrStb_t                              stb;
  logic [NUM_LVL-1:0][XLEN-1:0]         cfgVal;
  logic [NUM_LVL-1:0][CFG_GATE_W-1:0]   cfgGate;

  for (genvar lvl = 0; lvl < NUM_LVL; lvl++) begin : g_gate
    assign cfgGate[lvl] = cfgVal[lvl][CFG_GATE_LO +: CFG_GATE_W];
  end

  cbo_cfg_bank #(.XLEN(XLEN)) i_bank (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (csrWrData),
    .cfgVal (cfgVal),
    .rdData (csrRdData)
  );

  cbo_gate_ctrl #(
    .EN_BLOCK_MGMT (EN_BLOCK_MGMT),
    .EN_BLOCK_ZERO (EN_BLOCK_ZERO)
  ) i_ctrl (
    .instValid (instValid),
    .instWord  (instWord),
    .privLvl   (privLvl),
    .virtOn    (virtOn),
    .csrWrEn   (csrWrEn),
    .csrAddr   (csrAddr),
    .cfgGate   (cfgGate),
    .stb       (stb),
    .opOneHot  (opOneHot),
    .rs1Idx    (rs1Idx),
    .excCode   (excCode)
  );

endmodule

// File: rtl/cbo_gate_chk.sv
module cbo_gate_chk #(
  parameter int XLEN = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    instValid,
  input logic [1:0]              privLvl,
  input logic                    virtOn,
  input logic                    csrWrEn,
  input logic [11:0]             csrAddr,
  input logic [4:0]              opOneHot,
  input logic [1:0]              excCode,
  input logic [2:0][XLEN-1:0]    cfgVal
);

  // R1
  onehot_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(opOneHot));

  // R3
  pref_no_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    opOneHot[4] |-> excCode == 2'd0);

  // R5
  mach_wr_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 12'h30A && privLvl != 2'd3) |=> $stable(cfgVal[0]));

  // R5
  hyp_wr_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 12'h60A && privLvl < 2'd2) |=> $stable(cfgVal[1]));

  // R5
  sup_wr_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && csrAddr == 12'h10A && privLvl == 2'd0) |=> $stable(cfgVal[2]));

  // R7
  virt_needs_virt_chk: assert property (@(posedge clk) disable iff (!rstN)
    excCode == 2'd2 |-> virtOn);

  // R9
  mach_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl == 2'd3 && !virtOn && (|opOneHot)) |-> excCode == 2'd0);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (opOneHot == 5'd0 && excCode == 2'd0));

  // R11
  exc_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    excCode != 2'd3);

endmodule

bind cbo_gate cbo_gate_chk #(.XLEN(XLEN)) i_cbo_gate_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .privLvl   (privLvl),
  .virtOn    (virtOn),
  .csrWrEn   (csrWrEn),
  .csrAddr   (csrAddr),
  .opOneHot  (opOneHot),
  .excCode   (excCode),
  .cfgVal    (cfgVal)
);

// File: tb/test_cbo_gate.sv
module test_cbo_gate;

  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid;
  logic [31:0] instWord;
  logic [1:0]  privLvl;
  logic        virtOn;
  logic        csrWrEn;
  logic [11:0] csrAddr;
  logic [31:0] csrWrData;
  logic [31:0] csrRdData, csrRdDataOff;
  logic [4:0]  opOneHot, opOneHotOff;
  logic [4:0]  rs1Idx, rs1IdxOff;
  logic [1:0]  excCode, excCodeOff;

  always #2 clk = ~clk;

  cbo_gate i_cbo_gate (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .privLvl(privLvl), .virtOn(virtOn), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .opOneHot(opOneHot),
    .rs1Idx(rs1Idx), .excCode(excCode)
  );

  // Variant with management ops removed, zero kept
  cbo_gate #(.EN_BLOCK_MGMT(1'b0), .EN_BLOCK_ZERO(1'b1)) i_cbo_gate_off (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .privLvl(privLvl), .virtOn(virtOn), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdDataOff), .opOneHot(opOneHotOff),
    .rs1Idx(rs1IdxOff), .excCode(excCodeOff)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [3];   // 0 machine, 1 hypervisor, 2 supervisor

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCbo(input logic [4:0] sel, input logic [4:0] rs1);
    return {7'd0, sel, rs1, 3'b010, 5'd0, 7'b0001111};
  endfunction

  function automatic logic [31:0] mkPref(input logic [6:0] imm, input logic [4:0] sel, input logic [4:0] rs1);
    return {imm, sel, rs1, 3'b110, 5'd0, 7'b0010011};
  endfunction

  function automatic logic [4:0] expOp(input logic [31:0] w, input bit enMgmt, input bit enZero);
    logic [4:0] r;
    r = 5'd0;
    if (w[6:0] == 7'b0001111 && w[14:12] == 3'b010 && w[11:7] == 0 && w[31:25] == 0) begin
      if (w[24:20] == 5'b00001 && enMgmt) r = 5'b00001;
      if (w[24:20] == 5'b00010 && enMgmt) r = 5'b00010;
      if (w[24:20] == 5'b00000 && enMgmt) r = 5'b00100;
      if (w[24:20] == 5'b00100 && enZero) r = 5'b01000;
    end
    if (w[6:0] == 7'b0010011 && w[14:12] == 3'b110 && w[11:7] == 0 &&
        (w[24:20] == 5'd0 || w[24:20] == 5'd1 || w[24:20] == 5'd3))
      r = 5'b10000;
    return r;
  endfunction

  function automatic bit fieldSet(input logic [4:0] op, input logic [31:0] reg32);
    if (op[0] || op[1]) return reg32[6];
    if (op[2])          return reg32[5] | reg32[4];
    if (op[3])          return reg32[7];
    return 1'b0;
  endfunction

  function automatic logic [1:0] expExc(input logic [31:0] w, input logic [1:0] pv, input bit vt,
                                        input bit enMgmt, input bit enZero);
    logic [4:0] opAll, op;
    opAll = expOp(w, 1'b1, 1'b1);
    op    = expOp(w, enMgmt, enZero);
    if (opAll[3:0] != 0 && op == 0) return 2'd1;
    if (op[3:0] == 0) return 2'd0;
    if (vt && ((pv < 2 && !fieldSet(op, mdl[1])) || (pv == 0 && !fieldSet(op, mdl[2]))))
      return 2'd2;
    if ((pv < 3 && !fieldSet(op, mdl[0])) || (pv == 0 && !fieldSet(op, mdl[2])))
      return 2'd1;
    return 2'd0;
  endfunction

  task automatic checkInst(input logic [31:0] w, input logic [1:0] pv, input bit vt, input string tag);
    logic [4:0] eo;
    @(negedge clk);
    instWord = w; privLvl = pv; virtOn = vt; instValid = 1'b1;
    #1;
    eo = expOp(w, 1'b1, 1'b1);
    chk(opOneHot == eo, {tag, " op"}, 32'(opOneHot), 32'(eo));
    chk(rs1Idx == ((eo != 0) ? w[19:15] : 5'd0), {tag, " rs1"}, 32'(rs1Idx),
        32'((eo != 0) ? w[19:15] : 5'd0));
    chk(excCode == expExc(w, pv, vt, 1'b1, 1'b1), {tag, " exc"}, 32'(excCode),
        32'(expExc(w, pv, vt, 1'b1, 1'b1)));
    chk(opOneHotOff == expOp(w, 1'b0, 1'b1), {tag, " R10 op"}, 32'(opOneHotOff),
        32'(expOp(w, 1'b0, 1'b1)));
    chk(excCodeOff == expExc(w, pv, vt, 1'b0, 1'b1), {tag, " R10 exc"}, 32'(excCodeOff),
        32'(expExc(w, pv, vt, 1'b0, 1'b1)));
    instValid = 1'b0;
  endtask

  task automatic csrWrite(input logic [11:0] a, input logic [31:0] d, input logic [1:0] pv);
    @(negedge clk);
    csrAddr = a; csrWrData = d; privLvl = pv; csrWrEn = 1'b1;
    @(posedge clk);
    #1 csrWrEn = 1'b0;
    if (a == 12'h30A && pv == 3) mdl[0] = d;
    if (a == 12'h60A && pv >= 2) mdl[1] = d;
    if (a == 12'h10A && pv >= 1) mdl[2] = d;
  endtask

  task automatic csrCheck(input logic [11:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    csrAddr = a;
    #1;
    e = (a == 12'h30A) ? mdl[0] : (a == 12'h60A) ? mdl[1] : (a == 12'h10A) ? mdl[2] : 32'd0;
    chk(csrRdData == e, tag, csrRdData, e);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240117));
    rstN = 1'b0; instValid = 1'b0; instWord = '0; privLvl = 2'd0; virtOn = 1'b0;
    csrWrEn = 1'b0; csrAddr = '0; csrWrData = '0;
    mdl[0] = '0; mdl[1] = '0; mdl[2] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R4 reset values and unknown address
    csrCheck(12'h30A, "R4 reset m");
    csrCheck(12'h60A, "R4 reset h");
    csrCheck(12'h10A, "R4 reset s");
    csrWrite(12'h30B, 32'hFFFF_FFFF, 2'd3);
    csrCheck(12'h30B, "R4 unknown addr");

    // R11 idle
    @(negedge clk);
    instWord = mkCbo(5'b00001, 5'd7); privLvl = 2'd0; virtOn = 1'b1; instValid = 1'b0;
    #1;
    chk(opOneHot == 0, "R11 idle op", 32'(opOneHot), 0);
    chk(excCode == 0, "R11 idle exc", 32'(excCode), 0);

    // All registers zero
    checkInst(mkCbo(5'b00001, 5'd3), 2'd0, 1'b0, "R8 user clean");
    checkInst(mkCbo(5'b00010, 5'd4), 2'd1, 1'b0, "R8 super flush");
    checkInst(mkCbo(5'b00000, 5'd5), 2'd0, 1'b1, "R7 virt user inval");
    checkInst(mkCbo(5'b00100, 5'd6), 2'd1, 1'b1, "R7 virt super zero");
    checkInst(mkCbo(5'b00100, 5'd9), 2'd3, 1'b0, "R9 machine zero");
    checkInst(mkCbo(5'b00000, 5'd1), 2'd3, 1'b0, "R9 machine inval");
    checkInst(mkPref(7'h55, 5'd0, 5'd2), 2'd0, 1'b1, "R3 pref i");
    checkInst(mkPref(7'h7F, 5'd1, 5'd8), 2'd1, 1'b0, "R2 pref r");
    checkInst(mkPref(7'h01, 5'd3, 5'd31), 2'd0, 1'b0, "R3 pref w");
    checkInst(mkPref(7'h00, 5'd2, 5'd4), 2'd0, 1'b0, "R2 ori sel2");
    checkInst(mkPref(7'h00, 5'd0, 5'd4) | 32'h0000_0080, 2'd0, 1'b0, "R2 ori rd1");
    checkInst(mkCbo(5'b00001, 5'd3) | 32'h0200_0000, 2'd3, 1'b0, "R1 hi bit");
    checkInst(mkCbo(5'b00011, 5'd3), 2'd3, 1'b0, "R1 bad sel");
    checkInst(mkCbo(5'b00001, 5'd3) | 32'h0000_0800, 2'd3, 1'b0, "R1 rd nonzero");

    // R5 low-privilege writes dropped
    csrWrite(12'h30A, 32'h0000_00F0, 2'd1);
    csrCheck(12'h30A, "R5 m from super");
    csrWrite(12'h60A, 32'h0000_00F0, 2'd1);
    csrCheck(12'h60A, "R5 h from super");
    csrWrite(12'h10A, 32'h0000_00F0, 2'd0);
    csrCheck(12'h10A, "R5 s from user");
    csrWrite(12'h10A, 32'h0000_00F0, 2'd1);
    csrCheck(12'h10A, "R5 s from super");
    csrWrite(12'h60A, 32'h0000_00F0, 2'd3);
    csrCheck(12'h60A, "R5 h from machine");

    // R6 field mapping through the machine register
    csrWrite(12'h30A, 32'h0000_0040, 2'd3);
    csrCheck(12'h30A, "R4 m readback");
    checkInst(mkCbo(5'b00001, 5'd1), 2'd1, 1'b0, "R6 clean bit6");
    checkInst(mkCbo(5'b00010, 5'd1), 2'd1, 1'b0, "R6 flush bit6");
    checkInst(mkCbo(5'b00000, 5'd1), 2'd1, 1'b0, "R6 inval off");
    checkInst(mkCbo(5'b00100, 5'd1), 2'd1, 1'b0, "R6 zero off");
    csrWrite(12'h30A, 32'h0000_0010, 2'd3);
    checkInst(mkCbo(5'b00000, 5'd1), 2'd1, 1'b0, "R6 inval bit4");
    checkInst(mkCbo(5'b00001, 5'd1), 2'd1, 1'b0, "R6 clean off");
    csrWrite(12'h30A, 32'h0000_0020, 2'd3);
    checkInst(mkCbo(5'b00000, 5'd1), 2'd0, 1'b0, "R6 inval bit5");
    csrWrite(12'h30A, 32'h0000_0080, 2'd3);
    checkInst(mkCbo(5'b00100, 5'd1), 2'd0, 1'b0, "R6 zero bit7");

    // R7 precedence: hypervisor clear, machine clear
    csrWrite(12'h30A, 32'h0000_0000, 2'd3);
    csrWrite(12'h60A, 32'h0000_0000, 2'd3);
    checkInst(mkCbo(5'b00001, 5'd2), 2'd0, 1'b1, "R7 before R8");
    csrWrite(12'h60A, 32'h0000_00F0, 2'd3);
    checkInst(mkCbo(5'b00001, 5'd2), 2'd0, 1'b1, "R8 after virt pass");
    csrWrite(12'h30A, 32'h0000_00F0, 2'd3);
    csrWrite(12'h10A, 32'h0000_0000, 2'd3);
    checkInst(mkCbo(5'b00001, 5'd2), 2'd1, 1'b0, "R8 super ignores s");
    checkInst(mkCbo(5'b00001, 5'd2), 2'd0, 1'b0, "R8 user needs s");
    checkInst(mkCbo(5'b00001, 5'd2), 2'd0, 1'b1, "R7 user needs s");
    checkInst(mkCbo(5'b00100, 5'd2), 2'd3, 1'b0, "R10 zero kept");

    // Constrained random mix
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] w;
      logic [1:0]  pv;
      int kind;
      if (it % 20 == 0) begin
        logic [11:0] a;
        int pick;
        pick = $urandom_range(0, 3);
        a = (pick == 0) ? 12'h30A : (pick == 1) ? 12'h60A : (pick == 2) ? 12'h10A : 12'h10B;
        pv = ($urandom_range(0, 2) == 2) ? 2'd3 : 2'($urandom_range(0, 1));
        csrWrite(a, $urandom() & 32'h0000_00F0 | ($urandom() & 32'hFFFF_FF0F), pv);
        csrCheck(a, "R4 R5 random csr");
      end
      kind = $urandom_range(0, 5);
      case (kind)
        0, 1: w = mkCbo(5'($urandom_range(0, 4)), 5'($urandom()));
        2:    w = mkPref(7'($urandom()), 5'($urandom_range(0, 3)), 5'($urandom()));
        3:    w = mkCbo(5'($urandom()), 5'($urandom())) ^ (32'd1 << $urandom_range(7, 31));
        4:    w = mkPref(7'($urandom()), 5'($urandom()), 5'($urandom())) ^
                  (32'd1 << $urandom_range(7, 14));
        default: w = $urandom();
      endcase
      pv = ($urandom_range(0, 2) == 2) ? 2'd3 : 2'($urandom_range(0, 1));
      checkInst(w, pv, 1'($urandom()), "R1 R2 R3 R6 R7 R8 R9 random");
    end

    finishRun();
  end

endmodule